// File: doc/BRIEF.md
# Byte-Addressed Tuning Register Write Port

This block is the host-facing load port of a numerically controlled oscillator. A narrow 8-bit host bus fills three holding registers: two 32-bit frequency words, called bank A and bank B, and one 12-bit phase offset word. The oscillator core reads these registers continuously. Each write names its target register and byte lane through a 4-bit address. A write is qualified by an active-low select and starts on the rising edge of a write strobe. The strobe is asynchronous to the system clock.

The strobe passes through a two-flop synchroniser and then a rising-edge detector. On the single clock cycle that the detector flags, the block samples the select, address and data pins and updates exactly one byte lane, or no lane at all. Bytes that are not addressed keep their values. The host may load lanes in any order and may skip lanes that have not changed.

Top module: `tune_regs_wrport`

## Requirements
- R1: Address bits 3:2 pick the target register. 00 selects frequency bank A, 01 selects frequency bank B, and 10 or 11 selects the phase register. No other register changes on a write.
- R2: For either frequency bank, address bits 1:0 pick the byte lane. 00 writes bits 7:0, 01 writes bits 15:8, 10 writes bits 23:16 and 11 writes bits 31:24. All other bits of that bank keep their values.
- R3: Phase register, address bits 1:0 = 00: data bits 7:4 go to phase bits 3:0, and phase bits 11:4 keep their values. Address bits 1:0 = 01: data bits 7:0 go to phase bits 11:4, and phase bits 3:0 keep their values. Address bits 1:0 = 10 or 11 leave the phase register unchanged.
- R4: While the select is high at the detected strobe edge, no register changes.
- R5: A register changes only on the detected rising edge of the strobe. A strobe held high, a falling strobe or an idle strobe writes nothing.
- R6: The synchronous active-low reset clears bank A, bank B and the phase register to zero.
- R7: Suppose the strobe rises and is first sampled high at clock edge N. The write is then visible after clock edge N+2, and the outputs still hold their old values after edge N+1.
- R8: Lanes written in any order, with any lanes skipped, give the value formed by the most recent write to each lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low write select, sampled at the detected strobe edge |
| wr_stb | input | 1 | Asynchronous write strobe; its rising edge starts a write |
| addr | input | 4 | Target register (bits 3:2) and byte lane (bits 1:0) |
| wdata | input | 8 | Write data byte |
| freq_a | output | 32 | Frequency bank A holding value |
| freq_b | output | 32 | Frequency bank B holding value |
| phase_ofs | output | 12 | Phase offset holding value |

## Verification
The bench checks the phase low-lane nibble mapping. A design that copied data bits 3:0 there would give a wrong phase value whenever the two halves of the data byte differ. The bench writes to phase lanes 10 and 11. A decoder that only checked bit 0 would corrupt the phase register on those writes. The bench also holds the strobe high for several cycles and counts cycles around the strobe edge. A level-triggered design would write repeatedly, and a design with an extra or missing flop would update one cycle late or one cycle early. Random writes with random select values, in shuffled lane order, expose lane cross-talk between banks A and B and writes that leak through while the select is high.

// File: rtl/tune_pkg.sv
// Package: shared widths and address-field layout for the tuning register port.
// Assumes an 8-bit host bus and 32-bit frequency words made of whole bytes.
package tune_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int FREQ_W     = 32;
    localparam int PHASE_W    = 12;
    localparam int NUM_BANKS  = 2;
    localparam int LANES      = FREQ_W / DATA_W;
    localparam int LANE_SEL_W = $clog2(LANES);
    localparam int NIB_W      = DATA_W / 2;
    localparam int SYNC_DEPTH = 2;

    // Target field values carried on address bits 3:2
    typedef enum logic [1:0] {
        TGT_BANK_A = 2'b00,
        TGT_BANK_B = 2'b01,
        TGT_PHASE0 = 2'b10,
        TGT_PHASE1 = 2'b11
    } target_e;
endpackage

// File: rtl/tune_stb_sync.sv
// Module: tune_stb_sync
// Moves the asynchronous write strobe into the clock domain through a
// parameterised flop chain and emits a one-cycle pulse on each rising edge.
// Assumes the strobe stays high and low for longer than SYNC_DEPTH+1 clocks.
module tune_stb_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_async,
    output logic stb_rise
);
    logic [SYNC_DEPTH-1:0] chain_q;
    logic                  last_q;

    // Purpose: synchroniser chain, first flop takes the raw strobe
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_DEPTH-2:0], stb_async};
    end

    // Purpose: remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_DEPTH-1];
    end

    // Purpose: single-cycle pulse on a low-to-high synchronised transition
    always_comb stb_rise = chain_q[SYNC_DEPTH-1] & ~last_q;
endmodule

// File: rtl/tune_addr_dec.sv
// Module: tune_addr_dec
// Turns a qualified write (strobe pulse and low select) plus the address into
// one-hot lane enables for the frequency banks and the two phase lanes.
// Assumes the address and select are stable around the strobe pulse.
module tune_addr_dec
    import tune_pkg::*;
(
    input  logic                                 fire,
    input  logic                                 cs_n,
    input  logic [ADDR_W-1:0]                    addr,
    output logic [NUM_BANKS-1:0][LANES-1:0]      bank_we,
    output logic                                 ph_lo_we,
    output logic                                 ph_hi_we
);
    logic    go;
    target_e tgt;
    logic [LANE_SEL_W-1:0] lane;

    // Purpose: qualify the strobe pulse with the active-low select
    always_comb begin
        go   = fire & ~cs_n;
        tgt  = target_e'(addr[ADDR_W-1:ADDR_W-2]);
        lane = addr[LANE_SEL_W-1:0];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Purpose: one enable per bank byte lane
            always_comb bank_we[b][l] = go && (tgt == target_e'(b))
                                           && (lane == LANE_SEL_W'(l));
        end
    end

    // Purpose: phase lane enables; lane codes 10 and 11 decode to nothing
    always_comb begin
        ph_lo_we = go && addr[ADDR_W-1] && (lane == LANE_SEL_W'(0));
        ph_hi_we = go && addr[ADDR_W-1] && (lane == LANE_SEL_W'(1));
    end
endmodule

// File: rtl/tune_reg_bank.sv
// Module: tune_reg_bank
// Holds the frequency banks and the phase word; each enable updates its own
// lane only. The phase low lane takes the upper nibble of the data byte.
// Assumes at most one enable is high per cycle (guaranteed by the decoder).
module tune_reg_bank
    import tune_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [DATA_W-1:0]                    wdata,
    input  logic [NUM_BANKS-1:0][LANES-1:0]      bank_we,
    input  logic                                 ph_lo_we,
    input  logic                                 ph_hi_we,
    output logic [NUM_BANKS-1:0][FREQ_W-1:0]     bank_q,
    output logic [PHASE_W-1:0]                   phase_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Purpose: one byte lane of a frequency bank
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[b][l*DATA_W +: DATA_W] <= '0;
                else if (bank_we[b][l])
                    bank_q[b][l*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

    // Purpose: phase low nibble from data bits 7:4
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q[NIB_W-1:0] <= '0;
        else if (ph_lo_we) phase_q[NIB_W-1:0] <= wdata[DATA_W-1:NIB_W];
    end

    // Purpose: phase upper byte from the full data bus
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q[PHASE_W-1:NIB_W] <= '0;
        else if (ph_hi_we) phase_q[PHASE_W-1:NIB_W] <= wdata;
    end
endmodule

// File: rtl/tune_regs_wrport.sv
// Module: tune_regs_wrport (top)
// Host write port filling two frequency banks and a phase word from an 8-bit
// bus. Strobe synchronised, select/address/data sampled on the detected edge.
// Assumes addr, wdata and cs_n settle before the strobe rises and stay put
// until at least three clocks after it.
module tune_regs_wrport
    import tune_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               wr_stb,
    input  logic [3:0]         addr,
    input  logic [7:0]         wdata,
    output logic [31:0]        freq_a,
    output logic [31:0]        freq_b,
    output logic [11:0]        phase_ofs
);
    logic                             stb_rise;
    logic [NUM_BANKS-1:0][LANES-1:0]  bank_we;
    logic                             ph_lo_we;
    logic                             ph_hi_we;
    logic [NUM_BANKS-1:0][FREQ_W-1:0] bank_q;
    logic [PHASE_W-1:0]               phase_q;

    tune_stb_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_async (wr_stb),
        .stb_rise  (stb_rise)
    );

    tune_addr_dec u_dec (
        .fire     (stb_rise),
        .cs_n     (cs_n),
        .addr     (addr),
        .bank_we  (bank_we),
        .ph_lo_we (ph_lo_we),
        .ph_hi_we (ph_hi_we)
    );

    tune_reg_bank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (wdata),
        .bank_we  (bank_we),
        .ph_lo_we (ph_lo_we),
        .ph_hi_we (ph_hi_we),
        .bank_q   (bank_q),
        .phase_q  (phase_q)
    );

    // Purpose: expose the holding registers to the oscillator core
    always_comb begin
        freq_a    = bank_q[0];
        freq_b    = bank_q[1];
        phase_ofs = phase_q;
    end
endmodule

// File: rtl/tune_regs_wrport_chk.sv
// Module: tune_regs_wrport_chk
// Checker bound into the top: relates the synchronised strobe pulse, the pins
// and the register outputs over time.
module tune_regs_wrport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        stb_rise,
    input logic [3:0]  addr,
    input logic [31:0] freq_a,
    input logic [31:0] freq_b,
    input logic [11:0] phase_ofs
);
    // R6: reset clears every holding register
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (freq_a == '0 && freq_b == '0 && phase_ofs == '0));

    // R5: without a detected edge nothing moves
    a_r5_no_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> ($stable(freq_a) && $stable(freq_b) && $stable(phase_ofs)));

    // R4: select high blocks the write
    a_r4_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && cs_n) |=> ($stable(freq_a) && $stable(freq_b) && $stable(phase_ofs)));

    // R1: at most one register changes per cycle
    a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones({freq_a != $past(freq_a), freq_b != $past(freq_b),
                               phase_ofs != $past(phase_ofs)}) <= 1));

    // R2: only one byte lane of bank A changes per cycle
    a_r2_one_lane_a: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones({freq_a[31:24] != $past(freq_a[31:24]),
                               freq_a[23:16] != $past(freq_a[23:16]),
                               freq_a[15:8]  != $past(freq_a[15:8]),
                               freq_a[7:0]   != $past(freq_a[7:0])}) <= 1));

    // R3: phase lane codes 10 and 11 leave the phase word alone
    a_r3_phase_hi_codes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && !cs_n && addr[3] && addr[1]) |=> $stable(phase_ofs));
endmodule

bind tune_regs_wrport tune_regs_wrport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .stb_rise  (stb_rise),
    .addr      (addr),
    .freq_a    (freq_a),
    .freq_b    (freq_b),
    .phase_ofs (phase_ofs)
);

// File: tb/tune_regs_wrport_tb.sv
module tune_regs_wrport_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_stb = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] freq_a, freq_b;
    logic [11:0] phase_ofs;

    logic [31:0] m_a, m_b;
    logic [11:0] m_ph;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tune_regs_wrport u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata),
        .freq_a(freq_a), .freq_b(freq_b), .phase_ofs(phase_ofs)
    );

    // Expected frequency bank after a lane write
    function automatic logic [31:0] put_lane(logic [31:0] old, logic [1:0] ln, logic [7:0] d);
        logic [31:0] r = old;
        r[ln*8 +: 8] = d;
        return r;
    endfunction

    // Expected phase after a phase-target write
    function automatic logic [11:0] put_phase(logic [11:0] old, logic [1:0] ln, logic [7:0] d);
        logic [11:0] r = old;
        if (ln == 2'b00)      r[3:0]  = d[7:4];
        else if (ln == 2'b01) r[11:4] = d;
        return r;
    endfunction

    task automatic model(input logic [3:0] a, input logic [7:0] d, input logic c);
        if (!c) begin
            case (a[3:2])
                2'b00:   m_a  = put_lane(m_a, a[1:0], d);
                2'b01:   m_b  = put_lane(m_b, a[1:0], d);
                default: m_ph = put_phase(m_ph, a[1:0], d);
            endcase
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " freq_a"}, freq_a, m_a);
        check({req, " freq_b"}, freq_b, m_b);
        check({req, " phase"}, {20'd0, phase_ofs}, {20'd0, m_ph});
    endtask

    // One strobe cycle; inputs change on falling edges
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input logic c);
        @(negedge clk);
        addr = a; wdata = d; cs_n = c; wr_stb = 1'b1;
        repeat (5) @(negedge clk);
        wr_stb = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        model(a, d, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_a = '0; m_b = '0; m_ph = '0;
        @(negedge clk);
        check_all("R6 reset");

        // R7 latency: first sampled at edge N, unchanged after N+1, new after N+2
        @(negedge clk);
        addr = 4'b0000; wdata = 8'hA5; cs_n = 1'b0; wr_stb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 not yet", freq_a, 32'h0);
        @(negedge clk);
        check("R7 visible", freq_a, 32'h0000_00A5);
        // R5: strobe held high writes once only
        wdata = 8'h3C;
        repeat (4) @(negedge clk);
        check("R5 held strobe", freq_a, 32'h0000_00A5);
        wr_stb = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 falling edge", freq_a, 32'h0000_00A5);
        cs_n = 1'b1;
        m_a = 32'h0000_00A5;

        // R2/R8: out-of-order lanes on bank B
        bus_write(4'b0111, 8'h12, 1'b0);
        bus_write(4'b0100, 8'h78, 1'b0);
        bus_write(4'b0110, 8'h34, 1'b0);
        bus_write(4'b0101, 8'h56, 1'b0);
        check("R2 R8 bank B order", freq_b, 32'h1234_5678);
        check_all("R1 after bank B");

        // R3: nibble mapping and ignored lane codes
        bus_write(4'b1000, 8'h9E, 1'b0);
        check("R3 phase low nibble", {20'd0, phase_ofs}, 32'h009);
        bus_write(4'b1101, 8'hC7, 1'b0);
        check("R3 phase high byte", {20'd0, phase_ofs}, 32'hC79);
        bus_write(4'b1010, 8'hFF, 1'b0);
        bus_write(4'b1111, 8'h00, 1'b0);
        check("R3 lane 1x ignored", {20'd0, phase_ofs}, 32'hC79);

        // R4: select high blocks
        bus_write(4'b0011, 8'hEE, 1'b1);
        bus_write(4'b1001, 8'hEE, 1'b1);
        check_all("R4 cs high");

        // Random mix, fixed seed
        void'($urandom(32'd7135));
        for (int i = 0; i < 300; i++) begin
            logic [3:0] ra = 4'($urandom());
            logic [7:0] rd = 8'($urandom());
            logic       rc = ($urandom() % 5) == 0;
            bus_write(ra, rd, rc);
            check_all("R1 R2 R3 R4 R8 random");
        end

        // R6: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_a = '0; m_b = '0; m_ph = '0;
        check_all("R6 mid reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule